// File: doc/BRIEF.md
# Per-Pin GPIO Interrupt Controller

This block generates interrupts for a bank of general-purpose pins. Each pin arrives as an already filtered and synchronised level. A per-pin invert control can flip that level. A detector then watches the adjusted level, either for a rising transition (edge mode) or for a high level (level mode). A detected condition latches a status flag. Each pin has its own enable flag, and the pin's interrupt request is the AND of its status flag and its enable flag.

Software reaches the status and enable flags through one small command word per pin. Separate bits set the status, clear the status, set the enable and clear the enable, so one access can acknowledge and mask a pin together. Falling-edge and active-low interrupts have no mode bits of their own: software sets the pin's invert control so that the detector sees the opposite polarity. A read port returns the status and enable flags of any selected pin. Every control port is a plain signal, and the block has no streaming data path.

Top module: `gpint_ctrl`

## Requirements
- R1: After reset, every pin reads back 0 (status and enable both clear) and every interrupt request is low.
- R2: A write to the selected pin with bit 1 of the command set makes the status flag 1 from the next clock. The read word carries the status flag in bit 0.
- R3: A write with bit 0 of the command set clears the status flag, provided nothing sets it in the same cycle.
- R4: A command bit 3 sets the enable flag and a command bit 2 clears it. The read word carries the enable flag in bit 2. Bits 1 and 3 of the read word always read 0.
- R5: A pin's interrupt request is high exactly when both its status flag and its enable flag are 1.
- R6: In edge mode (edge select 1, detection enabled), a rising transition of the adjusted level sets the status flag at the clock edge that samples it. The flag then holds when the level falls or stays high, until a clear command removes it.
- R7: In level mode (edge select 0, detection enabled), the status flag is set on every clock at which the adjusted level is high, so a clear has no effect while that level stays high. Once the level is low, the flag stays latched until a clear command removes it.
- R8: When a pin's invert control is 1, the adjusted level is the inverse of the pin. Edge mode then responds to falling pin transitions and level mode responds to a low pin.
- R9: With detection disabled for a pin, activity on that pin never changes its status flag.
- R10: A set wins over a clear in the same cycle. This holds for a command with both bit 0 and bit 1 set, and for a detected condition that coincides with a clear command.
- R11: A single command with bits 0 and 2 both set clears status and enable together, and the interrupt request falls after that one access.
- R12: A command changes only the pin named by the write select. Every other pin keeps its flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_level | input | NUM_PINS | Filtered, synchronised pin levels |
| cfg_invert | input | NUM_PINS | Per-pin polarity inversion before detection |
| cfg_int_en | input | NUM_PINS | Per-pin detection enable |
| cfg_edge | input | NUM_PINS | Per-pin mode: 1 edge, 0 level |
| wr_en | input | 1 | Command strobe, one cycle per access |
| wr_sel | input | SEL_W | Pin addressed by the command |
| wr_data | input | 4 | Command: bit0 clear status, bit1 set status, bit2 clear enable, bit3 set enable |
| rd_sel | input | SEL_W | Pin shown on rd_data |
| rd_data | output | 4 | Bit0 status, bit2 enable, other bits 0 |
| irq | output | NUM_PINS | Per-pin interrupt request |

## Verification
The embedded properties assume three things about the inputs: pin levels are already synchronous to clk, the write select names an existing pin, and the configuration of a pin is stable around the cycles in which its detection is checked. The stimulus changes pins and commands only on the falling clock edge. It sets the per-pin configuration once, before reset is released. It holds each pin at its inactive adjusted level through reset, so that no stray transition appears when reset is released. Every write selects one of the eight pins, and the expected flags are scored against rd_data and irq half a cycle after each access.

// File: rtl/gpint_pkg.sv
package gpint_pkg;
  localparam int CMD_W = 4;

  // Command word layout, least significant field last.
  typedef struct packed {
    logic en_set;   // bit 3
    logic en_clr;   // bit 2
    logic st_set;   // bit 1
    logic st_clr;   // bit 0
  } gpint_cmd_t;
endpackage

// File: rtl/gpint_detect.sv
module gpint_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  input  logic invert,
  input  logic int_en,
  input  logic edge_mode,
  output logic lvl_adj,
  output logic hit_o
);
  logic prev_q;

  assign lvl_adj = pin ^ invert;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_adj;
  end

  always_comb begin
    if (!int_en)        hit_o = 1'b0;
    else if (edge_mode) hit_o = lvl_adj & ~prev_q;
    else                hit_o = lvl_adj;
  end
endmodule

// File: rtl/gpint_state.sv
module gpint_state
  import gpint_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  gpint_cmd_t cmd,
  input  logic       hit_i,
  output logic       status,
  output logic       enable
);
  logic st_set, st_clr, en_set, en_clr;

  assign st_set = hit_i | (sel & cmd.st_set);
  assign st_clr = sel & cmd.st_clr;
  assign en_set = sel & cmd.en_set;
  assign en_clr = sel & cmd.en_clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= 1'b0;
      enable <= 1'b0;
    end else begin
      status <= st_set | (status & ~st_clr);
      enable <= en_set | (enable & ~en_clr);
    end
  end

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st_set |=> status);
  // R3
  clear_works_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr && !st_set) |=> !status);
  // R9
  no_spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!status && !st_set) |=> !status);
  // R4
  en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_set |=> enable);
  // R11
  en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_clr && !en_set) |=> !enable);
endmodule

// File: rtl/gpint_ctrl.sv
module gpint_ctrl
  import gpint_pkg::*;
#(
  parameter int NUM_PINS = 8,
  localparam int SEL_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_level,
  input  logic [NUM_PINS-1:0] cfg_invert,
  input  logic [NUM_PINS-1:0] cfg_int_en,
  input  logic [NUM_PINS-1:0] cfg_edge,
  input  logic                wr_en,
  input  logic [SEL_W-1:0]    wr_sel,
  input  logic [CMD_W-1:0]    wr_data,
  input  logic [SEL_W-1:0]    rd_sel,
  output logic [CMD_W-1:0]    rd_data,
  output logic [NUM_PINS-1:0] irq
);
  gpint_cmd_t          cmd;
  logic [NUM_PINS-1:0] st_vec, en_vec, lvl_vec, hit_vec;

  assign cmd = gpint_cmd_t'(wr_data);

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    logic sel_p;
    assign sel_p = wr_en && (wr_sel == SEL_W'(p));

    gpint_detect u_det (
      .clk(clk), .rst_n(rst_n), .pin(pin_level[p]), .invert(cfg_invert[p]),
      .int_en(cfg_int_en[p]), .edge_mode(cfg_edge[p]),
      .lvl_adj(lvl_vec[p]), .hit_o(hit_vec[p])
    );

    gpint_state u_st (
      .clk(clk), .rst_n(rst_n), .sel(sel_p), .cmd(cmd), .hit_i(hit_vec[p]),
      .status(st_vec[p]), .enable(en_vec[p])
    );

    // R7
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_int_en[p] && !cfg_edge[p] && lvl_vec[p]) |=> st_vec[p]);
  end

  assign irq     = st_vec & en_vec;
  assign rd_data = {1'b0, en_vec[rd_sel], 1'b0, st_vec[rd_sel]};
endmodule

// File: tb/gpint_ctrl_test.sv
module gpint_ctrl_test;
  localparam int N = 8;
  localparam int SW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] pin_level = 8'b0001_1000;
  logic [N-1:0] cfg_invert = 8'b0001_1000;
  logic [N-1:0] cfg_int_en = 8'b0111_1100 & 8'b0011_1100;
  logic [N-1:0] cfg_edge = 8'b0100_1100;
  logic wr_en = 1'b0;
  logic [SW-1:0] wr_sel = '0, rd_sel = '0;
  logic [3:0] wr_data = '0;
  logic [3:0] rd_data;
  logic [N-1:0] irq;

  gpint_ctrl #(.NUM_PINS(N)) uut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .cfg_invert(cfg_invert),
    .cfg_int_en(cfg_int_en), .cfg_edge(cfg_edge), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .irq(irq)
  );

  always #4 clk = ~clk;

  typedef struct {
    string    req;
    int       pin;
    logic [3:0] rd;
    logic     irq;
  } item_t;
  item_t sb[$];
  int checks = 0, fails = 0;
  bit done = 0;

  // Monitor: pops expected items and compares against outputs.
  initial forever begin
    @(negedge clk);
    #2;
    while (sb.size() > 0) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (rd_data !== it.rd || irq[it.pin] !== it.irq) begin
        fails++;
        $display("FAIL %s pin%0d rd=%h irq=%b expected rd=%h irq=%b",
                 it.req, it.pin, rd_data, irq[it.pin], it.rd, it.irq);
      end
    end
  end

  task automatic expect_pin(string req, int p, logic [3:0] rd, logic ir);
    item_t it;
    @(negedge clk);
    rd_sel = SW'(p);
    it.req = req; it.pin = p; it.rd = rd; it.irq = ir;
    sb.push_back(it);
  endtask

  task automatic cmd_write(int p, logic [3:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = SW'(p); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic drive_pin(int p, logic v);
    @(negedge clk);
    pin_level[p] = v;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_pin("R1", 0, 4'h0, 1'b0);
    expect_pin("R1", 3, 4'h0, 1'b0);
    expect_pin("R1", 4, 4'h0, 1'b0);
    // R2 status set, R5 masked
    cmd_write(0, 4'h2);
    expect_pin("R2", 0, 4'h1, 1'b0);
    // R4 enable set, R5 irq
    cmd_write(0, 4'h8);
    expect_pin("R5", 0, 4'h5, 1'b1);
    // R12 other pin untouched
    expect_pin("R12", 1, 4'h0, 1'b0);
    // R3 clear status
    cmd_write(0, 4'h1);
    expect_pin("R3", 0, 4'h4, 1'b0);
    // R4 clear enable
    cmd_write(0, 4'h4);
    expect_pin("R4", 0, 4'h0, 1'b0);
    // R10 set beats clear in one command
    cmd_write(0, 4'h3);
    expect_pin("R10", 0, 4'h1, 1'b0);
    cmd_write(0, 4'h8);
    // R11 combined acknowledge and mask
    cmd_write(0, 4'h5);
    expect_pin("R11", 0, 4'h0, 1'b0);

    // R6 edge mode on pin 2
    cmd_write(2, 4'h8);
    drive_pin(2, 1'b1);
    expect_pin("R6", 2, 4'h5, 1'b1);
    drive_pin(2, 1'b0);
    expect_pin("R6", 2, 4'h5, 1'b1);
    cmd_write(2, 4'h1);
    expect_pin("R6", 2, 4'h4, 1'b0);
    drive_pin(2, 1'b1);
    expect_pin("R6", 2, 4'h5, 1'b1);
    cmd_write(2, 4'h1);
    expect_pin("R6", 2, 4'h4, 1'b0);
    // R10 edge coinciding with a clear
    drive_pin(2, 1'b0);
    @(negedge clk);
    pin_level[2] = 1'b1;
    wr_en = 1'b1; wr_sel = 3'd2; wr_data = 4'h1;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    expect_pin("R10", 2, 4'h5, 1'b1);

    // R8 inverted edge on pin 3: falling pin is detected
    drive_pin(3, 1'b0);
    expect_pin("R8", 3, 4'h1, 1'b0);

    // R7/R8 inverted level on pin 4
    drive_pin(4, 1'b0);
    expect_pin("R8", 4, 4'h1, 1'b0);
    cmd_write(4, 4'h1);
    expect_pin("R7", 4, 4'h1, 1'b0);
    drive_pin(4, 1'b1);
    expect_pin("R7", 4, 4'h1, 1'b0);
    cmd_write(4, 4'h1);
    expect_pin("R7", 4, 4'h0, 1'b0);

    // R7 plain level on pin 5
    drive_pin(5, 1'b1);
    expect_pin("R7", 5, 4'h1, 1'b0);

    // R9 detection disabled on pin 6
    drive_pin(6, 1'b1);
    drive_pin(6, 1'b0);
    drive_pin(6, 1'b1);
    expect_pin("R9", 6, 4'h0, 1'b0);
    expect_pin("R12", 7, 4'h0, 1'b0);

    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule